// File: doc/BRIEF.md
# Serial Identification Memory Responder

This block is a 128-byte identification memory that answers on a two-wire serial bus. The bus side is a slave that samples SCL and SDA with the system clock. It pulls SDA low through an open-drain enable. Most bytes are fixed identification constants held in logic. A few groups of bytes can be loaded: the model-dependent bytes, a 16-byte unique identifier and an 8-byte date code. A narrow parallel side port loads them, and nothing else can change them.

The two checksum locations are never stored as plain bytes. Each one is a running sum over its own byte range. The sum is adjusted in the same cycle that a side-port load changes a byte in that range, so any later bus read returns a checksum that matches the current contents. A bus master reads with the usual pattern for a two-wire serial memory. It can write a word address and then issue a repeated START to read from that address. It can also read from the current pointer without writing an address first. Bus writes are accepted on the bus but leave the contents unchanged.

Top module: `serial_id_eeprom`

## Requirements
- R1: After reset the SDA enable is low, the byte pointer is 0, and every loadable byte reads 00h. A reset during operation restores the same state, including both checksum values.
- R2: The block acknowledges the 7-bit device address 1010000 (bus byte A0h for a write, A1h for a read) by driving SDA low in the ninth clock. Any other device address gets no acknowledge, and the block stays silent until the next START.
- R3: A random read returns the byte at the word address that was written. The fixed contents are: 0=03h, 1=04h, 6=08h, 11=01h, 12=0Dh, 18=64h. Bytes 20..24 hold ASCII "IDMEM" and bytes 25..35 hold 20h. Bytes 36..39 hold 01h 00h 2Ch 5Ah. Bytes 40..46 hold ASCII "XCVR-01" and bytes 52..59 hold 20h. All other bytes that are not loadable and not checksums read 00h.
- R4: In a read, the pointer advances by one after each byte sent. When the master acknowledges a byte, the next byte follows, and the pointer wraps from 127 to 0.
- R5: A read that is not preceded by an address write starts at the current pointer.
- R6: When the master answers a byte with no acknowledge and then sends STOP, the transfer ends, SDA is released, and a new transfer can follow. The SDA enable changes only while SCL is low.
- R7: Byte 63 reads as the low 8 bits of the unsigned sum of bytes 0..62.
- R8: Byte 95 reads as the low 8 bits of the unsigned sum of bytes 64..94.
- R9: A side-port load to a loadable address changes that byte and its checksum. The loadable addresses are 47..51, 65 (model bytes), 68..83 (identifier) and 84..91 (date code). A load to any other address has no effect.
- R10: Data bytes written over the bus are acknowledged but do not change the contents. The pointer still advances by one for each such byte.
- R11: Bit 7 of the written word address is ignored. Bytes 96..127 are a reserved area that reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the bus lines are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| ld_we | input | 1 | Side-port load strobe, one cycle per byte |
| ld_addr | input | 7 | Side-port byte address |
| ld_data | input | 8 | Side-port byte value |

## Verification
The bench builds the block with its default parameters: device address 1010000 and a two-stage synchronizer on each bus line. With these values, the real A0h/A1h bus bytes exercise address matching, and a neighbouring address (A2h) exercises rejection. The synchronizer depth sets how many system clocks pass between an SCL edge and the moment SDA responds. That latency lets a bench bit period of a few tens of clocks cover every turnaround: acknowledge, data launch and release. The checksum sums are checked both on the fixed image and after loads that change bytes in both ranges.

// File: rtl/sid_pkg.sv
package sid_pkg;

    localparam int AW        = 7;
    localparam int NSLOT     = 30;
    localparam int SLOT_W    = $clog2(NSLOT);

    localparam logic [AW-1:0] CSUM_LO_A = 7'd63;
    localparam logic [AW-1:0] CSUM_HI_A = 7'd95;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_RLOAD
    } bus_state_e;

    typedef struct packed {
        bus_state_e      st;
        logic [2:0]      cnt;
        logic [7:0]      sh;
        logic [AW-1:0]   ptr;
        logic            rw;
        logic            oe;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, cnt: 3'd0, sh: 8'd0,
                                 ptr: '0, rw: 1'b0, oe: 1'b0};

    // Constant image of the non-loadable bytes.
    function automatic logic [7:0] fixed_byte(input logic [AW-1:0] a);
        logic [7:0] v;
        v = 8'h00;
        if (a inside {[7'd25:7'd35]} || a inside {[7'd52:7'd59]})
            v = 8'h20;
        case (a)
            7'd0:  v = 8'h03;
            7'd1:  v = 8'h04;
            7'd6:  v = 8'h08;
            7'd11: v = 8'h01;
            7'd12: v = 8'h0D;
            7'd18: v = 8'h64;
            7'd20: v = 8'h49;
            7'd21: v = 8'h44;
            7'd22: v = 8'h4D;
            7'd23: v = 8'h45;
            7'd24: v = 8'h4D;
            7'd36: v = 8'h01;
            7'd38: v = 8'h2C;
            7'd39: v = 8'h5A;
            7'd40: v = 8'h58;
            7'd41: v = 8'h43;
            7'd42: v = 8'h56;
            7'd43: v = 8'h52;
            7'd44: v = 8'h2D;
            7'd45: v = 8'h30;
            7'd46: v = 8'h31;
            default: ;
        endcase
        return v;
    endfunction

    function automatic logic is_loadable(input logic [AW-1:0] a);
        return (a inside {[7'd47:7'd51]}) || (a == 7'd65) ||
               (a inside {[7'd68:7'd91]});
    endfunction

    function automatic logic [SLOT_W-1:0] slot_index(input logic [AW-1:0] a);
        logic [AW-1:0] t;
        t = '0;
        if (a inside {[7'd47:7'd51]})      t = a - 7'd47;
        else if (a == 7'd65)               t = 7'd5;
        else if (a inside {[7'd68:7'd91]}) t = a - 7'd62;
        return t[SLOT_W-1:0];
    endfunction

    // Sum of the constant bytes of a range; loadable bytes reset to zero.
    function automatic logic [7:0] fixed_sum(input int lo, input int hi);
        logic [7:0] s;
        s = 8'h00;
        for (int a = lo; a <= hi; a++) begin
            if (!is_loadable(7'(a)))
                s = s + fixed_byte(7'(a));
        end
        return s;
    endfunction

endpackage

// File: rtl/sid_bus_sync.sv
module sid_bus_sync
    import sid_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int SW = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

    typedef struct packed {
        logic [SW-1:0] scl_p;
        logic [SW-1:0] sda_p;
        logic          scl_prev;
        logic          sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  scl_now, sda_now;

    always_comb begin
        scl_now        = sync_q.scl_p[SW-1];
        sda_now        = sync_q.sda_p[SW-1];
        sync_d         = sync_q;
        sync_d.scl_p   = (sync_q.scl_p << 1) | SW'(scl_i);
        sync_d.sda_p   = (sync_q.sda_p << 1) | SW'(sda_i);
        sync_d.scl_prev = scl_now;
        sync_d.sda_prev = sda_now;

        sda_s     = sda_now;
        scl_rise  = scl_now & ~sync_q.scl_prev;
        scl_fall  = ~scl_now & sync_q.scl_prev;
        start_det = scl_now & sync_q.scl_prev & sync_q.sda_prev & ~sda_now;
        stop_det  = scl_now & sync_q.scl_prev & ~sync_q.sda_prev & sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

endmodule

// File: rtl/sid_id_store.sv
module sid_id_store
    import sid_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte,
    output logic [7:0]    csum_lo,
    output logic [7:0]    csum_hi
);

    localparam logic [7:0] FIX_LO = fixed_sum(0, 62);
    localparam logic [7:0] FIX_HI = fixed_sum(64, 94);

    typedef struct packed {
        logic [NSLOT-1:0][7:0] slot;
        logic [7:0]            lo;
        logic [7:0]            hi;
    } store_t;

    store_t st_d, st_q;
    logic [SLOT_W-1:0] wr_idx, rd_idx;
    logic [7:0]        old_b;

    always_comb begin
        st_d   = st_q;
        wr_idx = slot_index(ld_addr);
        old_b  = st_q.slot[wr_idx];
        if (ld_we && is_loadable(ld_addr)) begin
            st_d.slot[wr_idx] = ld_data;
            // Incremental update: remove the old byte, add the new one.
            if (ld_addr < CSUM_LO_A)
                st_d.lo = st_q.lo + ld_data - old_b;
            else
                st_d.hi = st_q.hi + ld_data - old_b;
        end
    end

    always_comb begin
        rd_idx  = slot_index(rd_addr);
        rd_byte = is_loadable(rd_addr) ? st_q.slot[rd_idx] : fixed_byte(rd_addr);
        csum_lo = st_q.lo;
        csum_hi = st_q.hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.slot <= '0;
            st_q.lo   <= FIX_LO;
            st_q.hi   <= FIX_HI;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/serial_id_eeprom.sv
module serial_id_eeprom
    import sid_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       ld_we,
    input  logic [6:0] ld_addr,
    input  logic [7:0] ld_data
);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    sid_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    ctl_t       ctl_d, ctl_q;
    logic [7:0] store_byte, csum_lo, csum_hi, rd_byte, byte_in;
    logic       ptr_load;

    sid_id_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .rd_addr (ctl_q.ptr),
        .rd_byte (store_byte),
        .csum_lo (csum_lo),
        .csum_hi (csum_hi)
    );

    always_comb begin
        if (ctl_q.ptr == CSUM_LO_A)      rd_byte = csum_lo;
        else if (ctl_q.ptr == CSUM_HI_A) rd_byte = csum_hi;
        else                             rd_byte = store_byte;
    end

    always_comb begin
        ctl_d    = ctl_q;
        ptr_load = 1'b0;
        byte_in  = {ctl_q.sh[6:0], sda_s};

        if (stop_det) begin
            ctl_d.st = ST_IDLE;
            ctl_d.oe = 1'b0;
        end else if (start_det) begin
            ctl_d.st  = ST_DEV;
            ctl_d.cnt = 3'd0;
            ctl_d.oe  = 1'b0;
        end else begin
            unique case (ctl_q.st)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        ctl_d.sh  = byte_in;
                        ctl_d.cnt = ctl_q.cnt + 3'd1;
                        if (ctl_q.cnt == 3'd7) begin
                            if (ctl_q.st == ST_DEV) begin
                                if (byte_in[7:1] == DEV_ADDR) begin
                                    ctl_d.st = ST_DEV_ACK;
                                    ctl_d.rw = byte_in[0];
                                end else begin
                                    ctl_d.st = ST_IDLE;
                                end
                            end else if (ctl_q.st == ST_WADDR) begin
                                ctl_d.ptr = byte_in[AW-1:0];
                                ptr_load  = 1'b1;
                                ctl_d.st  = ST_WADDR_ACK;
                            end else begin
                                ctl_d.ptr = ctl_q.ptr + 7'd1;
                                ctl_d.st  = ST_WDATA_ACK;
                            end
                        end
                    end
                end
                ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        if (!ctl_q.oe) begin
                            ctl_d.oe = 1'b1;
                        end else begin
                            ctl_d.oe  = 1'b0;
                            ctl_d.cnt = 3'd0;
                            if (ctl_q.st == ST_DEV_ACK && ctl_q.rw) begin
                                ctl_d.sh = rd_byte;
                                ctl_d.oe = ~rd_byte[7];
                                ctl_d.st = ST_RDATA;
                            end else if (ctl_q.st == ST_DEV_ACK) begin
                                ctl_d.st = ST_WADDR;
                            end else begin
                                ctl_d.st = ST_WDATA;
                            end
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        ctl_d.sh = ctl_q.sh << 1;
                        ctl_d.oe = ~ctl_q.sh[6];
                    end else if (scl_rise) begin
                        ctl_d.cnt = ctl_q.cnt + 3'd1;
                        if (ctl_q.cnt == 3'd7) begin
                            ctl_d.ptr = ctl_q.ptr + 7'd1;
                            ctl_d.st  = ST_RACK;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_fall)
                        ctl_d.oe = 1'b0;
                    else if (scl_rise)
                        ctl_d.st = sda_s ? ST_IDLE : ST_RLOAD;
                end
                ST_RLOAD: begin
                    if (scl_fall) begin
                        ctl_d.sh  = rd_byte;
                        ctl_d.oe  = ~rd_byte[7];
                        ctl_d.cnt = 3'd0;
                        ctl_d.st  = ST_RDATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign sda_oe = ctl_q.oe;

endmodule

// File: rtl/sid_checker.sv
module sid_checker
    import sid_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe,
    input bus_state_e    st,
    input logic [AW-1:0] ptr,
    input logic          ptr_load,
    input logic [7:0]    csum_lo,
    input logic [7:0]    csum_hi,
    input logic          ld_we,
    input logic [AW-1:0] ld_addr
);

    always @(posedge clk) begin
        if (!rst_n) assert_released_in_reset_R1: assert (!sda_oe);
    end

    assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

    assert_ptr_step_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> ($past(ptr_load) || ptr == $past(ptr) + 7'd1));

    assert_oe_moves_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    assert_csum_lo_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(csum_lo) |-> ($past(ld_we) && $past(ld_addr) < 7'd63));

    assert_csum_hi_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(csum_hi) |-> ($past(ld_we) && $past(ld_addr) > 7'd63));

endmodule

bind serial_id_eeprom sid_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .st       (ctl_q.st),
    .ptr      (ctl_q.ptr),
    .ptr_load (ptr_load),
    .csum_lo  (csum_lo),
    .csum_hi  (csum_hi),
    .ld_we    (ld_we),
    .ld_addr  (ld_addr)
);

// File: tb/serial_id_eeprom_tb_top.sv
module serial_id_eeprom_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       ld_we = 1'b0;
    logic [6:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic       sda_oe;
    wire        sda_line = sda_m & ~sda_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    serial_id_eeprom dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_data (ld_data)
    );

    // {word address, expected byte} for random reads (R3, R11)
    localparam logic [14:0] VEC [12] = '{
        {7'd0,   8'h03}, {7'd1,  8'h04}, {7'd6,  8'h08}, {7'd11, 8'h01},
        {7'd12,  8'h0D}, {7'd18, 8'h64}, {7'd20, 8'h49}, {7'd24, 8'h4D},
        {7'd30,  8'h20}, {7'd38, 8'h2C}, {7'd46, 8'h31}, {7'd100, 8'h00}
    };

    logic [7:0] ref_mem [128];

    function automatic logic [7:0] ref_fixed(input int a);
        string nm = "IDMEM";
        string pn = "XCVR-01";
        if (a >= 20 && a <= 24) return 8'(nm[a-20]);
        if (a >= 40 && a <= 46) return 8'(pn[a-40]);
        if ((a >= 25 && a <= 35) || (a >= 52 && a <= 59)) return 8'h20;
        case (a)
            0: return 8'h03;  1: return 8'h04;  6: return 8'h08;
            11: return 8'h01; 12: return 8'h0D; 18: return 8'h64;
            36: return 8'h01; 38: return 8'h2C; 39: return 8'h5A;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit ref_loadable(input int a);
        return (a >= 47 && a <= 51) || a == 65 || (a >= 68 && a <= 91);
    endfunction

    task automatic ref_reset();
        for (int a = 0; a < 128; a++) ref_mem[a] = ref_fixed(a);
    endtask

    function automatic logic [7:0] ref_read(input int a);
        logic [7:0] s = 8'h00;
        if (a == 63) begin
            for (int i = 0; i <= 62; i++) s += ref_mem[i];
            return s;
        end
        if (a == 95) begin
            for (int i = 64; i <= 94; i++) s += ref_mem[i];
            return s;
        end
        return ref_mem[a];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (5) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        ack = ~sda_line;
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_line; scl_m = 1'b0;
        end
        wq(); sda_m = nack; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic addr_phase(input logic [7:0] wa);
        logic ack;
        bus_start();
        send_byte(8'hA0, ack); chk("R2 write address ack", 8'(ack), 8'h01);
        send_byte(wa, ack);    chk("R2 word address ack", 8'(ack), 8'h01);
    endtask

    task automatic seq_read(input logic [7:0] wa, input int n, input string req);
        logic ack;
        logic [7:0] d;
        addr_phase(wa);
        bus_rstart();
        send_byte(8'hA1, ack); chk("R2 read address ack", 8'(ack), 8'h01);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, d);
            chk(req, d, ref_read((int'(wa[6:0]) + i) % 128));
        end
        bus_stop();
    endtask

    task automatic cur_read(input int start, input int n, input string req);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(8'hA1, ack); chk("R2 read address ack", 8'(ack), 8'h01);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, d);
            chk(req, d, ref_read((start + i) % 128));
        end
        bus_stop();
    endtask

    task automatic side_load(input int a, input logic [7:0] v);
        @(negedge clk); ld_we = 1'b1; ld_addr = 7'(a); ld_data = v;
        @(negedge clk); ld_we = 1'b0;
        if (ref_loadable(a)) ref_mem[a] = v;
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_up();
        end
    end

    initial begin
        logic ack;
        ref_reset();
        repeat (3) @(negedge clk);
        chk("R1 sda released in reset", 8'(sda_oe), 8'h00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 sda released after reset", 8'(sda_oe), 8'h00);
        // R1 / R5: pointer starts at 0
        cur_read(0, 2, "R5 current read from reset pointer");

        // Table walk: random reads of fixed bytes (R3, R11 reserved area)
        for (int i = 0; i < 12; i++)
            seq_read({1'b0, VEC[i][14:8]}, 1, "R3 random read");
        for (int i = 0; i < 12; i++) chk("R3 table", ref_read(int'(VEC[i][14:8])), VEC[i][7:0]);

        // R1: loadable bytes start at zero; R7/R8 on the fixed image
        seq_read(8'd70, 1, "R1 loadable byte after reset");
        seq_read(8'd63, 1, "R7 checksum low range fixed image");
        seq_read(8'd95, 1, "R8 checksum high range fixed image");

        // R2: wrong device address is not acknowledged
        bus_start();
        send_byte(8'hA2, ack); chk("R2 foreign address nack", 8'(ack), 8'h00);
        send_byte(8'h00, ack); chk("R2 silent until start", 8'(ack), 8'h00);
        bus_stop();

        // R9: side-port loads in both checksum ranges
        for (int a = 47; a <= 51; a++) side_load(a, 8'(8'h30 + a));
        side_load(65, 8'h5A);
        for (int a = 68; a <= 91; a++) side_load(a, 8'(a * 7 + 3));
        seq_read(8'd47, 5, "R9 model bytes loaded");
        seq_read(8'd60, 8, "R7 R4 sequential across low checksum");
        seq_read(8'd90, 7, "R8 R4 sequential across high checksum");
        seq_read(8'd80, 1, "R9 identifier byte loaded");
        // R9: loads outside the loadable set have no effect
        side_load(20, 8'hFF);
        side_load(63, 8'h11);
        side_load(100, 8'h22);
        seq_read(8'd20, 1, "R9 fixed byte not loadable");
        seq_read(8'd63, 1, "R9 R7 checksum unchanged by ignored load");
        seq_read(8'd100, 1, "R9 R11 reserved byte not loadable");

        // R4: wrap from 127 to 0
        seq_read(8'd126, 4, "R4 sequential wrap");

        // R5: current read after an address-only write
        addr_phase(8'd20);
        bus_stop();
        cur_read(20, 1, "R5 current read after address set");
        cur_read(21, 1, "R5 current read continues");

        // R10: bus writes acknowledged, ignored, pointer advances
        addr_phase(8'd10);
        send_byte(8'hFF, ack); chk("R10 data ack", 8'(ack), 8'h01);
        send_byte(8'hEE, ack); chk("R10 data ack", 8'(ack), 8'h01);
        bus_stop();
        cur_read(12, 1, "R10 pointer advanced past written bytes");
        seq_read(8'd10, 2, "R10 written bytes unchanged");

        // R11: bit 7 of the word address ignored
        seq_read(8'h8C, 1, "R11 word address bit 7 ignored");

        // R6: released after NACK + STOP, next transfer works
        chk("R6 sda released after stop", 8'(sda_oe), 8'h00);
        chk("R6 line high after stop", 8'(sda_line), 8'h01);
        seq_read(8'd0, 1, "R6 transfer after nack stop");

        // R1: reset during operation clears loads and checksums
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ref_reset();
        repeat (3) @(negedge clk);
        chk("R1 sda released after mid-run reset", 8'(sda_oe), 8'h00);
        cur_read(0, 1, "R1 pointer cleared by reset");
        seq_read(8'd80, 1, "R1 loadable cleared by reset");
        seq_read(8'd63, 1, "R1 R7 low checksum restored");
        seq_read(8'd95, 1, "R1 R8 high checksum restored");

        done = 1;
        finish_up();
    end

endmodule